// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block is the interrupt front end of a two-channel serial controller. Each channel, A and B, has three interrupt sources: a received byte, a transmit-buffer-empty event and a break condition. The block keeps a pending flag and an in-service flag for the receive and transmit sources of each channel. From these it drives one combined interrupt request, a pending-status byte and a modified vector byte whose layout depends on a status-high/status-low mode bit.

Software reaches the block over a byte-wide port with a channel select and a control/data select. On the control side an indirect register pointer picks the register for the next access. Register 0 takes commands and loads the pointer. Register 1 holds the interrupt enables, register 9 the mode bit and channel reset commands, and register 15 the break enable. On the data side a read takes the received byte and a write marks the transmitter busy and then empty again. Serial framing and bit timing are outside this block. Receive bytes and break conditions arrive as one-cycle event inputs.

Top module: `sio_irq_vector_ctrl`

## Requirements
- R1: While a channel's pointer is 0, a control write loads the pointer from wdata[2:0]. If the command field wdata[5:3] is 3'b001, bit 3 of the pointer is also set, which reaches registers 8 to 15. A control write while the pointer is non-zero writes the selected register and returns the pointer to 0. A control read of register 15 returns its stored value, which is 0xF8 after reset.
- R2: A control read returns the register selected by that channel's pointer and returns the pointer to 0. Register 0 reads {break, 0000, tx-empty=1, 0, rx-available}. Registers with no read function read 0x00.
- R3: Command field 3'b101, written to register 0, clears the channel's transmit pending and transmit in-service flags.
- R4: Command field 3'b111, written to register 0, clears receive in-service if it is set. If receive in-service is already clear, it clears transmit in-service instead. When it clears receive in-service and transmit is still pending, transmit is taken into service.
- R5: A pending transmit interrupt is taken into service only while no receive interrupt of that channel is in service. A data read clears the receive interrupt, and after it a still-pending transmit interrupt is taken into service.
- R6: Register 3 read through channel A gives the pending-status byte: bit5 rx A, bit4 tx A, bit3 break A, bit2 rx B, bit1 tx B, bit0 break B. Register 3 read through channel B gives 0x00. A tx bit is pending AND tx enable AND no rx in service. An rx bit is rx pending. A break bit is break status AND break enable.
- R7: Register 2, read through either channel, gives the vector of the highest in-service source, in the order rx A, tx A, rx B, tx B. In status-low mode the values are 0x0C, 0x08, 0x04 and 0x00, and 0x06 when nothing is in service. In status-high mode (register 9 bit 4 = 1) they are 0x30, 0x10, 0x20 and 0x00, and 0x60 when nothing is in service.
- R8: A channel requests an interrupt when any of these holds: register 1 bit 1 is set and transmit is pending; register 1 bits 4:3 equal 01 or 10 and receive is pending; register 15 bit 7 is set and break status is set. irq is the OR over both channels.
- R9: A write to register 9 of either channel resets channel A when bit 7 is set and channel B when bit 6 is set. A reset clears every flag and register 1, sets register 15 to 0xF8 and returns the pointer to 0. Bit 4 of the write is stored as the status-high mode bit.
- R10: A receive event sets rx-available, receive pending and receive in-service, and latches the byte. A data read returns that byte and clears all three. A data write sets transmit pending.
- R11: A break event sets the channel's break status bit (register 0 bit 7). Only a channel reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_chan | input | 1 | Channel select, 0 = A, 1 = B |
| bus_data_port | input | 1 | 0 = control port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid during a read strobe |
| rx_evt | input | 2 | Byte received, bit 0 = A, bit 1 = B |
| rx_byte_a | input | 8 | Received byte for channel A |
| rx_byte_b | input | 8 | Received byte for channel B |
| brk_evt | input | 2 | Break detected, bit 0 = A, bit 1 = B |
| irq | output | 1 | Combined interrupt request |

## Verification
Directed sequences check the transmit hold-off. A receive is put in service first, and a transmit pending behind it must not appear in the vector or the pending byte until a data read or a reset-in-service command releases it. This separates a correct rx-before-tx ordering from a design that services in arrival order. The same states are read in both vector modes, and with sources on both channels at once, which checks the A-before-B ordering and both vector layouts. Random mixes of receive, break, data and command traffic, enable writes and occasional channel resets follow. After every step the irq output is compared with the enable-gated equation, which separates the receive-mode decode and the break gating from a plain OR of the pending flags.

// File: rtl/sioiv_pkg.sv
package sioiv_pkg;
  localparam int BYTE_W = 8;
  localparam int PTR_W  = 4;
  localparam int NCH    = 2;
  localparam int CODE_W = 3;

  localparam logic [2:0] CMD_POINT_HI = 3'b001;
  localparam logic [2:0] CMD_CLR_TX   = 3'b101;
  localparam logic [2:0] CMD_RST_IUS  = 3'b111;

  localparam logic [PTR_W-1:0] REG_CMD    = 4'd0;
  localparam logic [PTR_W-1:0] REG_IE     = 4'd1;
  localparam logic [PTR_W-1:0] RD_VEC     = 4'd2;
  localparam logic [PTR_W-1:0] RD_PEND    = 4'd3;
  localparam logic [PTR_W-1:0] REG_MASTER = 4'd9;
  localparam logic [PTR_W-1:0] REG_EXTEN  = 4'd15;

  localparam logic [BYTE_W-1:0] EXTEN_RESET = 8'hF8;

  typedef struct packed {
    logic rx_avail;
    logic rx_pend;
    logic rx_ius;
    logic tx_pend;
    logic tx_ius;
    logic brk;
  } chan_flags_t;

  // Interrupt request of one channel from its enables and flags.
  function automatic logic chan_wants_irq(input logic tx_en, input logic [1:0] rx_mode,
                                          input logic brk_en, input logic rx_pend,
                                          input logic tx_pend, input logic brk);
    logic rx_on;
    rx_on = (rx_mode == 2'b01) || (rx_mode == 2'b10);
    return (tx_en && tx_pend) || (rx_on && rx_pend) || (brk_en && brk);
  endfunction

  // Source code: [2] = channel A, [1] = receive; 3'b011 means idle.
  function automatic logic [CODE_W-1:0] src_code(input logic [NCH-1:0] rx_ius,
                                                 input logic [NCH-1:0] tx_ius);
    if (rx_ius[0])      return 3'b110;
    else if (tx_ius[0]) return 3'b100;
    else if (rx_ius[1]) return 3'b010;
    else if (tx_ius[1]) return 3'b000;
    else                return 3'b011;
  endfunction

  // Status-low puts the code in bits 3:1; status-high puts it bit-reversed in bits 6:4.
  function automatic logic [BYTE_W-1:0] vec_format(input logic hi, input logic [CODE_W-1:0] code);
    if (hi) return {1'b0, code[0], code[1], code[2], 4'b0000};
    else    return {4'b0000, code, 1'b0};
  endfunction
endpackage

// File: rtl/sioiv_chan.sv
module sioiv_chan
  import sioiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_rst,
  input  logic              rx_evt,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              brk_evt,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              cmd_clr_tx,
  input  logic              cmd_rst_ius,
  input  logic              ie_we,
  input  logic              exten_we,
  input  logic [BYTE_W-1:0] wdata,
  output chan_flags_t       flags_q,
  output logic              tx_en_q,
  output logic [1:0]        rx_mode_q,
  output logic [BYTE_W-1:0] exten_q,
  output logic [BYTE_W-1:0] rx_data_q
);
  chan_flags_t nxt;
  logic        take_tx;

  always_comb begin
    nxt = flags_q;
    if (cmd_clr_tx) begin
      nxt.tx_pend = 1'b0;
      nxt.tx_ius  = 1'b0;
    end
    if (cmd_rst_ius) begin
      if (flags_q.rx_ius) nxt.rx_ius = 1'b0;
      else                nxt.tx_ius = 1'b0;
    end
    if (data_rd) begin
      nxt.rx_avail = 1'b0;
      nxt.rx_pend  = 1'b0;
      nxt.rx_ius   = 1'b0;
    end
    if (data_wr) nxt.tx_pend = 1'b1;
    if (rx_evt) begin
      nxt.rx_avail = 1'b1;
      nxt.rx_pend  = 1'b1;
      nxt.rx_ius   = 1'b1;
    end
    if (brk_evt) nxt.brk = 1'b1;
    // transmit goes into service only with no receive in service
    take_tx = nxt.tx_pend && !nxt.rx_ius &&
              (data_wr || data_rd || (cmd_rst_ius && flags_q.rx_ius));
    if (take_tx) nxt.tx_ius = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      tx_en_q   <= 1'b0;
      rx_mode_q <= 2'b00;
      exten_q   <= EXTEN_RESET;
      rx_data_q <= '0;
    end else if (chan_rst) begin
      flags_q   <= '0;
      tx_en_q   <= 1'b0;
      rx_mode_q <= 2'b00;
      exten_q   <= EXTEN_RESET;
      rx_data_q <= '0;
    end else begin
      flags_q <= nxt;
      if (rx_evt) rx_data_q <= rx_byte;
      if (ie_we) begin
        tx_en_q   <= wdata[1];
        rx_mode_q <= wdata[4:3];
      end
      if (exten_we) exten_q <= wdata;
    end
  end
endmodule

// File: rtl/sioiv_vec.sv
module sioiv_vec
  import sioiv_pkg::*;
(
  input  logic [NCH-1:0]   rx_pend,
  input  logic [NCH-1:0]   tx_pend,
  input  logic [NCH-1:0]   rx_ius,
  input  logic [NCH-1:0]   tx_ius,
  input  logic [NCH-1:0]   brk,
  input  logic [NCH-1:0]   tx_en,
  input  logic [2*NCH-1:0] rx_mode,
  input  logic [NCH-1:0]   brk_en,
  input  logic             status_hi,
  output logic [BYTE_W-1:0] vec,
  output logic [3*NCH-1:0] pend,
  output logic             irq
);
  logic [NCH-1:0] ch_irq;
  logic [2:0]     ch_pend [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_irq[c]  = chan_wants_irq(tx_en[c], rx_mode[2*c +: 2], brk_en[c],
                                       rx_pend[c], tx_pend[c], brk[c]);
    assign ch_pend[c] = {rx_pend[c], tx_pend[c] & tx_en[c] & ~rx_ius[c], brk[c] & brk_en[c]};
  end

  // channel A occupies the upper half of the pending byte
  assign pend = {ch_pend[0], ch_pend[1]};
  assign irq  = |ch_irq;
  assign vec  = vec_format(status_hi, src_code(rx_ius, tx_ius));
endmodule

// File: rtl/sio_irq_vector_ctrl.sv
module sio_irq_vector_ctrl
  import sioiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic              bus_chan,
  input  logic              bus_data_port,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    rx_evt,
  input  logic [BYTE_W-1:0] rx_byte_a,
  input  logic [BYTE_W-1:0] rx_byte_b,
  input  logic [NCH-1:0]    brk_evt,
  output logic              irq
);
  // named internal events, also observed by the checker
  logic [NCH-1:0]       ev_ctl_wr, ev_ctl_rd, ev_data_wr, ev_data_rd;
  logic [NCH-1:0]       ev_clr_tx, ev_rst_ius, ev_chan_rst, ev_master_wr;
  logic [PTR_W*NCH-1:0] ev_ptr_pair;
  logic [NCH-1:0]       ev_rx_pend, ev_tx_pend, ev_rx_ius, ev_tx_ius, ev_brk;
  logic [NCH-1:0]       tx_en_v, brk_en_v;
  logic [2*NCH-1:0]     rx_mode_v;
  logic [BYTE_W-1:0]    vec_w;
  logic [3*NCH-1:0]     pend_w;
  logic                 status_hi_q;
  logic                 master_we;

  logic [PTR_W-1:0]  ptr_q     [NCH];
  chan_flags_t       flags     [NCH];
  logic [BYTE_W-1:0] exten     [NCH];
  logic [BYTE_W-1:0] rx_data   [NCH];
  logic [BYTE_W-1:0] rx_byte_in[NCH];

  assign rx_byte_in[0] = rx_byte_a;
  assign rx_byte_in[1] = rx_byte_b;

  assign master_we      = |ev_master_wr;
  // bit 7 resets channel A, bit 6 resets channel B
  assign ev_chan_rst[0] = master_we & bus_wdata[7];
  assign ev_chan_rst[1] = master_we & bus_wdata[6];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, at_cmd;
    assign sel             = bus_cs && (bus_chan == c[0]);
    assign ev_ctl_wr[c]    = sel &&  bus_we && !bus_data_port;
    assign ev_ctl_rd[c]    = sel && !bus_we && !bus_data_port;
    assign ev_data_wr[c]   = sel &&  bus_we &&  bus_data_port;
    assign ev_data_rd[c]   = sel && !bus_we &&  bus_data_port;
    assign at_cmd          = (ptr_q[c] == REG_CMD);
    assign ev_clr_tx[c]    = ev_ctl_wr[c] && at_cmd && (bus_wdata[5:3] == CMD_CLR_TX);
    assign ev_rst_ius[c]   = ev_ctl_wr[c] && at_cmd && (bus_wdata[5:3] == CMD_RST_IUS);
    assign ev_master_wr[c] = ev_ctl_wr[c] && (ptr_q[c] == REG_MASTER);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ptr_q[c] <= '0;
      end else if (ev_chan_rst[c]) begin
        ptr_q[c] <= '0;
      end else if (ev_ctl_wr[c]) begin
        if (at_cmd) ptr_q[c] <= {bus_wdata[5:3] == CMD_POINT_HI, bus_wdata[2:0]};
        else        ptr_q[c] <= '0;
      end else if (ev_ctl_rd[c]) begin
        ptr_q[c] <= '0;
      end
    end

    sioiv_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .chan_rst   (ev_chan_rst[c]),
      .rx_evt     (rx_evt[c]),
      .rx_byte    (rx_byte_in[c]),
      .brk_evt    (brk_evt[c]),
      .data_wr    (ev_data_wr[c]),
      .data_rd    (ev_data_rd[c]),
      .cmd_clr_tx (ev_clr_tx[c]),
      .cmd_rst_ius(ev_rst_ius[c]),
      .ie_we      (ev_ctl_wr[c] && (ptr_q[c] == REG_IE)),
      .exten_we   (ev_ctl_wr[c] && (ptr_q[c] == REG_EXTEN)),
      .wdata      (bus_wdata),
      .flags_q    (flags[c]),
      .tx_en_q    (tx_en_v[c]),
      .rx_mode_q  (rx_mode_v[2*c +: 2]),
      .exten_q    (exten[c]),
      .rx_data_q  (rx_data[c])
    );

    assign ev_ptr_pair[PTR_W*c +: PTR_W] = ptr_q[c];
    assign ev_rx_pend[c] = flags[c].rx_pend;
    assign ev_tx_pend[c] = flags[c].tx_pend;
    assign ev_rx_ius[c]  = flags[c].rx_ius;
    assign ev_tx_ius[c]  = flags[c].tx_ius;
    assign ev_brk[c]     = flags[c].brk;
    assign brk_en_v[c]   = exten[c][7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_hi_q <= 1'b0;
    else if (master_we) status_hi_q <= bus_wdata[4];
  end

  sioiv_vec u_vec (
    .rx_pend  (ev_rx_pend),
    .tx_pend  (ev_tx_pend),
    .rx_ius   (ev_rx_ius),
    .tx_ius   (ev_tx_ius),
    .brk      (ev_brk),
    .tx_en    (tx_en_v),
    .rx_mode  (rx_mode_v),
    .brk_en   (brk_en_v),
    .status_hi(status_hi_q),
    .vec      (vec_w),
    .pend     (pend_w),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_cs && !bus_we) begin
      if (bus_data_port) begin
        bus_rdata = rx_data[bus_chan];
      end else begin
        case (ptr_q[bus_chan])
          REG_CMD:   bus_rdata = {flags[bus_chan].brk, 4'b0000, 1'b1, 1'b0,
                                  flags[bus_chan].rx_avail};
          RD_VEC:    bus_rdata = vec_w;
          RD_PEND:   bus_rdata = bus_chan ? 8'h00 : {2'b00, pend_w};
          REG_EXTEN: bus_rdata = exten[bus_chan];
          default:   bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sioiv_chk.sv
module sioiv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ctl_wr,
  input logic [1:0] ctl_rd,
  input logic [1:0] clr_tx,
  input logic [1:0] chan_rst,
  input logic [7:0] wdata,
  input logic [7:0] ptr_pair,
  input logic [1:0] rx_pend,
  input logic [1:0] tx_pend,
  input logic [1:0] rx_ius,
  input logic [1:0] tx_ius,
  input logic [1:0] brk,
  input logic [7:0] vec,
  input logic       irq
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    a_r1_ptr_home: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr[c] && ptr_pair[4*c +: 4] != 4'd0) |=> (ptr_pair[4*c +: 4] == 4'd0));
    a_r1_point_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr[c] && ptr_pair[4*c +: 4] == 4'd0 && wdata[5:3] == 3'b001) |=> ptr_pair[4*c + 3]);
    a_r2_read_home: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rd[c] |=> (ptr_pair[4*c +: 4] == 4'd0));
    a_r3_clr_tx: assert property (@(posedge clk) disable iff (!rst_n)
      clr_tx[c] |=> !tx_pend[c] && !tx_ius[c]);
    a_r5_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ius[c]) |-> !rx_ius[c]);
    a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
      chan_rst[c] |=> !(rx_pend[c] || tx_pend[c] || rx_ius[c] || tx_ius[c] || brk[c]));
  end

  a_r7_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ius == 2'b00 && tx_ius == 2'b00) |-> (vec == 8'h06 || vec == 8'h60));
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend == 2'b00 && tx_pend == 2'b00 && brk == 2'b00) |-> !irq);
endmodule

bind sio_irq_vector_ctrl sioiv_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctl_wr  (ev_ctl_wr),
  .ctl_rd  (ev_ctl_rd),
  .clr_tx  (ev_clr_tx),
  .chan_rst(ev_chan_rst),
  .wdata   (bus_wdata),
  .ptr_pair(ev_ptr_pair),
  .rx_pend (ev_rx_pend),
  .tx_pend (ev_tx_pend),
  .rx_ius  (ev_rx_ius),
  .tx_ius  (ev_tx_ius),
  .brk     (ev_brk),
  .vec     (vec_w),
  .irq     (irq)
);

// File: tb/sio_irq_vector_ctrl_tb.sv
module sio_irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0, bus_we = 1'b0, bus_chan = 1'b0, bus_data_port = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [1:0] rx_evt = '0, brk_evt = '0;
  logic [7:0] rx_byte_a = '0, rx_byte_b = '0;
  logic       irq;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // reference state, index 0 = A, 1 = B
  bit       m_rxav[2], m_rxp[2], m_rxs[2], m_txp[2], m_txs[2], m_brk[2];
  bit [7:0] m_ie[2], m_ext[2], m_rxb[2];
  bit [3:0] m_ptr[2];
  bit       m_hi;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we), .bus_chan(bus_chan),
    .bus_data_port(bus_data_port), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_evt(rx_evt), .rx_byte_a(rx_byte_a), .rx_byte_b(rx_byte_b),
    .brk_evt(brk_evt), .irq(irq)
  );

  task automatic m_reset_chan(input int c);
    m_rxav[c] = 0; m_rxp[c] = 0; m_rxs[c] = 0; m_txp[c] = 0; m_txs[c] = 0; m_brk[c] = 0;
    m_ie[c] = 8'h00; m_ext[c] = 8'hF8; m_rxb[c] = 8'h00; m_ptr[c] = 4'd0;
  endtask

  function automatic bit m_chan_irq(input int c);
    bit rx_mode_ok;
    rx_mode_ok = (m_ie[c][4:3] == 2'b01) || (m_ie[c][4:3] == 2'b10);
    return (m_ie[c][1] & m_txp[c]) | (rx_mode_ok & m_rxp[c]) | (m_ext[c][7] & m_brk[c]);
  endfunction

  function automatic bit [7:0] m_vector();
    if (m_rxs[0])      return m_hi ? 8'h30 : 8'h0C;
    else if (m_txs[0]) return m_hi ? 8'h10 : 8'h08;
    else if (m_rxs[1]) return m_hi ? 8'h20 : 8'h04;
    else if (m_txs[1]) return 8'h00;
    else               return m_hi ? 8'h60 : 8'h06;
  endfunction

  function automatic bit [7:0] m_pend();
    bit [7:0] p = 8'h00;
    if (m_rxp[0]) p |= 8'h20;
    if (m_txp[0] && m_ie[0][1] && !m_rxs[0]) p |= 8'h10;
    if (m_brk[0] && m_ext[0][7]) p |= 8'h08;
    if (m_rxp[1]) p |= 8'h04;
    if (m_txp[1] && m_ie[1][1] && !m_rxs[1]) p |= 8'h02;
    if (m_brk[1] && m_ext[1][7]) p |= 8'h01;
    return p;
  endfunction

  function automatic bit [7:0] m_rr(input int c, input int r);
    case (r)
      0:  return {m_brk[c], 4'b0000, 1'b1, 1'b0, m_rxav[c]};
      2:  return m_vector();
      3:  return (c == 0) ? m_pend() : 8'h00;
      15: return m_ext[c];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input bit [7:0] got, input bit [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic check_irq();
    check("R8 irq", {7'b0, irq}, {7'b0, m_chan_irq(0) | m_chan_irq(1)});
  endtask

  task automatic cyc(input bit cs, input bit we, input int c, input bit dp, input bit [7:0] wd,
                     input bit [1:0] rxm, input bit [7:0] rb, input bit [1:0] bkm,
                     output bit [7:0] rd);
    @(negedge clk);
    bus_cs = cs; bus_we = we; bus_chan = c[0]; bus_data_port = dp; bus_wdata = wd;
    rx_evt = rxm; brk_evt = bkm; rx_byte_a = rb; rx_byte_b = ~rb;
    #1 rd = bus_rdata;
    @(posedge clk);
    #1;
    bus_cs = 0; bus_we = 0; rx_evt = '0; brk_evt = '0;
  endtask

  task automatic do_rx(input int c, input bit [7:0] b);
    bit [7:0] rd;
    cyc(0, 0, c, 0, 8'h00, c == 0 ? 2'b01 : 2'b10, b, 2'b00, rd);
    m_rxav[c] = 1; m_rxp[c] = 1; m_rxs[c] = 1; m_rxb[c] = (c == 0) ? b : ~b;
    check_irq();
  endtask

  task automatic do_brk(input int c);
    bit [7:0] rd;
    cyc(0, 0, c, 0, 8'h00, 2'b00, 8'h00, c == 0 ? 2'b01 : 2'b10, rd);
    m_brk[c] = 1;
    check_irq();
  endtask

  task automatic do_dwr(input int c, input bit [7:0] v);
    bit [7:0] rd;
    cyc(1, 1, c, 1, v, 2'b00, 8'h00, 2'b00, rd);
    m_txp[c] = 1;
    if (!m_rxs[c]) m_txs[c] = 1;
    check_irq();
  endtask

  task automatic do_drd(input int c);
    bit [7:0] rd;
    cyc(1, 0, c, 1, 8'h00, 2'b00, 8'h00, 2'b00, rd);
    check("R10 data read byte", rd, m_rxb[c]);
    m_rxav[c] = 0; m_rxp[c] = 0; m_rxs[c] = 0;
    if (m_txp[c]) m_txs[c] = 1;
    check_irq();
  endtask

  // control write at whatever the pointer currently selects
  task automatic do_cwr(input int c, input bit [7:0] v);
    bit [7:0] rd;
    int p;
    p = m_ptr[c];
    cyc(1, 1, c, 0, v, 2'b00, 8'h00, 2'b00, rd);
    if (p == 0) begin
      m_ptr[c] = {v[5:3] == 3'b001, v[2:0]};
      if (v[5:3] == 3'b101) begin m_txp[c] = 0; m_txs[c] = 0; end
      if (v[5:3] == 3'b111) begin
        if (m_rxs[c]) begin m_rxs[c] = 0; if (m_txp[c]) m_txs[c] = 1; end
        else m_txs[c] = 0;
      end
    end else begin
      m_ptr[c] = 0;
      if (p == 1) m_ie[c] = v;
      if (p == 15) m_ext[c] = v;
      if (p == 9) begin
        m_hi = v[4];
        if (v[7]) m_reset_chan(0);
        if (v[6]) m_reset_chan(1);
      end
    end
    check_irq();
  endtask

  task automatic select_reg(input int c, input int r);
    do_cwr(c, (r < 8) ? r[7:0] : (8'h08 | r[7:0] - 8'd8));
  endtask

  task automatic do_wreg(input int c, input int r, input bit [7:0] v);
    select_reg(c, r);
    do_cwr(c, v);
  endtask

  task automatic do_rreg(input int c, input int r, input string tag);
    bit [7:0] rd, exp;
    select_reg(c, r);
    exp = m_rr(c, r);
    cyc(1, 0, c, 0, 8'h00, 2'b00, 8'h00, 2'b00, rd);
    m_ptr[c] = 0;
    check(tag, rd, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit [7:0] rd;
    void'($urandom(32'h5EED_1234));
    m_reset_chan(0); m_reset_chan(1); m_hi = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;

    // reset state
    check_irq();
    do_rreg(0, 0, "R2 reset status A");
    do_rreg(1, 2, "R7 reset vector");
    do_rreg(0, 3, "R6 reset pending");
    do_rreg(1, 3, "R6 pending via B reads zero");
    do_rreg(0, 5, "R2 unimplemented reads zero");

    // R1 point-high: WR0 0x0F reaches register 15
    do_cwr(0, 8'h0F);
    cyc(1, 0, 0, 0, 8'h00, 2'b00, 8'h00, 2'b00, rd);
    m_ptr[0] = 0;
    check("R1 point-high read of reg 15", rd, 8'hF8);
    // R2 pointer returned to 0: next plain read is status
    cyc(1, 0, 0, 0, 8'h00, 2'b00, 8'h00, 2'b00, rd);
    check("R2 pointer back at status", rd, m_rr(0, 0));

    // R5/R4: rx in service holds off tx on channel A
    do_wreg(0, 1, 8'h12);            // tx enable, rx mode 10
    do_rx(0, 8'hA5);
    do_rreg(0, 0, "R10 rx available");
    do_dwr(0, 8'h11);
    do_rreg(0, 3, "R5 tx held in pending byte");
    do_rreg(0, 2, "R5 vector shows rx A");
    do_cwr(0, 8'h38);                // reset in-service: rx out, tx in
    do_rreg(0, 2, "R4 tx taken after rx IUS reset");
    do_rreg(0, 3, "R6 tx A bit");
    do_cwr(0, 8'h38);                // clears tx in-service
    do_rreg(0, 2, "R4 second reset clears tx IUS");
    do_drd(0);
    do_rreg(0, 2, "R5 tx re-raised after data read");
    do_cwr(0, 8'h28);
    do_rreg(0, 3, "R3 tx cleared");
    check("R3 irq after clear", {7'b0, irq}, 8'h00);

    // R7 both channels, both modes
    do_rx(1, 8'h3C);
    do_dwr(0, 8'h22);
    do_rreg(1, 2, "R7 A before B, low mode");
    do_wreg(1, 9, 8'h10);
    do_rreg(0, 2, "R7 A before B, high mode");
    do_cwr(0, 8'h28);
    do_rreg(0, 2, "R7 rx B high mode");
    do_drd(1);
    do_dwr(1, 8'h01);
    do_rreg(0, 2, "R7 tx B high mode");

    // R11 break and R9 reset
    do_brk(1);
    do_rreg(1, 0, "R11 break status");
    do_wreg(1, 15, 8'h00);
    check("R8 break masked", {7'b0, irq}, {7'b0, m_chan_irq(0) | m_chan_irq(1)});
    do_wreg(1, 15, 8'h80);
    do_wreg(0, 9, 8'h50);            // reset B, keep high mode
    do_rreg(1, 0, "R9 reset B clears break");
    do_rreg(1, 15, "R9 reset B restores reg 15");
    do_rreg(0, 2, "R9 vector idle after reset");
    do_wreg(0, 9, 8'hC0);
    do_rreg(0, 3, "R9 full reset pending");

    // random traffic
    for (int i = 0; i < 1500; i++) begin
      int c, a;
      c = $urandom_range(0, 1);
      a = $urandom_range(0, 13);
      case (a)
        0, 1:  do_rx(c, 8'($urandom));
        2:     if ($urandom_range(0, 3) == 0) do_brk(c);
        3, 4:  do_dwr(c, 8'($urandom));
        5, 6:  do_drd(c);
        7:     do_cwr(c, 8'h28);
        8:     do_cwr(c, 8'h38);
        9:     do_wreg(c, 1, 8'($urandom) & 8'h1A);
        10:    do_wreg(c, 15, 8'($urandom) & 8'h88);
        11:    do_wreg(c, 9, {($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b00,
                              1'b0, 1'($urandom), 4'h0});
        default: begin
          int r;
          r = $urandom_range(0, 3);
          if (r == 1) r = 15;
          do_rreg(c, r, r == 2 ? "R7 random vector" :
                        r == 3 ? "R6 random pending" :
                        r == 0 ? "R2 random status" : "R1 random reg 15");
        end
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule